// File: doc/BRIEF.md
# Short-Vector Register Address Sequencer

This block turns one floating-point short-vector request into a stream of operand register numbers. The caller presents a start pulse with a destination register, a first-source register, a second-source register, a precision select, a vector length and a stride. The block then issues one element per handshake on its output. Each element carries a destination, first-source and second-source register number, an element index, a last flag, the operation class, and two flags that say whether each source has to be read for that element.

Register numbers stay inside fixed banks as they advance. In single precision a bank holds eight registers, and stepping changes only the low three bits. In double precision a bank holds four registers, and stepping changes only the low two bits. Operands in the first bank are scalars. If the destination is scalar, the whole operation is a single element. If the destination is a vector and the second source is scalar, the operation is mixed: the second source stays put while the other operands advance. Three forms are supported: three-operand, two-operand and immediate move. In the two-operand form a scalar source gives a one-to-many broadcast, and in the immediate-move form only the destination is sequenced.

The output follows valid/ready rules. Once `out_valid_o` is high, it stays high and every output field stays constant until `out_ready_i` is seen high at a clock edge. An element is consumed on each edge where both are high. The control inputs are plain: a start is taken only while `busy_o` is low.

Top module: `svseq_top`

## Requirements
- R1: The scalar bank is detected from register bits [4:3] equal to zero in single precision (`dbl_i`=0) and from bits [3:2] equal to zero in double precision (`dbl_i`=1). `out_kind_o` is 0 for scalar, 1 for mixed and 2 for vector. Mixed means the destination is a vector and the second source is scalar.
- R2: If the destination is in the scalar bank, or the length is 0, exactly one element is issued. That element has index 0, has `out_last_o` high and has kind 0, whatever length was given.
- R3: Otherwise length L gives L+1 elements with indices 0..L. `out_last_o` is high only on index L. The first element carries the input register numbers unchanged.
- R4: The step between elements is stride+1 in single precision and (stride>>1)+1 in double precision.
- R5: Advancing a register adds the step to its low 3 bits modulo 8 (single) or its low 2 bits modulo 4 (double). All higher bits are left unchanged.
- R6: In a mixed operation the second source keeps its start value on every element while the destination and first source advance. `out_ldb_o` is high on element 0 only.
- R7: The form is selected by `form_i`: 0 = three-operand, 1 = two-operand, 2 = immediate move. `out_lda_o` is high on every element of the three-operand form and never otherwise. In the two-operand form with a scalar source (kind 1), the source is read on element 0 only. With a vector source (kind 2), `out_ldb_o` is high on every element.
- R8: In the immediate-move form `out_lda_o` and `out_ldb_o` are always 0 and the kind is never 1. Only the destination (and the unused first-source field) advances, and the second-source field stays at its start value.
- R9: While `out_valid_o` is high and `out_ready_i` is low, every output field holds its value.
- R10: A start pulse while `busy_o` is high is ignored. After the last element is accepted, `out_valid_o` and `busy_o` are low on the next cycle.
- R11: After reset `out_valid_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| form_i | input | 2 | 0 three-operand, 1 two-operand, 2 immediate move |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| dst_i | input | 5 | Start destination register |
| srca_i | input | 5 | Start first-source register |
| srcb_i | input | 5 | Start second-source register |
| len_i | input | 3 | Vector length (elements minus one) |
| stride_i | input | 2 | Stride field |
| busy_o | output | 1 | A sequence is in progress |
| out_valid_o | output | 1 | Element available |
| out_ready_i | input | 1 | Consumer accepts the element |
| out_dst_o | output | 5 | Destination register of this element |
| out_srca_o | output | 5 | First-source register of this element |
| out_srcb_o | output | 5 | Second-source register of this element |
| out_idx_o | output | 3 | Element index |
| out_last_o | output | 1 | Final element |
| out_kind_o | output | 2 | Operation class |
| out_lda_o | output | 1 | First source must be read |
| out_ldb_o | output | 1 | Second source must be read |

## Verification
The bench targets bank wrap-around: a sequence that starts near the top of a bank must fall back to the bank's base. A design that let the carry reach the upper bits would move the operand into the next bank. It covers double-precision scalar banks at registers 16..19, which a check of bit 4 would misclassify as vector, and a stride of 3 in double precision, which a design would get wrong if it did not halve the stride. Scalar destinations given a large length must still yield one element, and mixed and broadcast operations must hold the second source; a design that advanced it would read the wrong registers. Stalled handshakes and a start pulse sent mid-sequence check that nothing moves without an accept and that a busy request is not taken up.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
  localparam int SP_LOW = 3;  // index bits inside a single-precision bank
  localparam int DP_LOW = 2;  // index bits inside a double-precision bank

  typedef enum logic [1:0] {
    FORM_3OP = 2'd0,
    FORM_2OP = 2'd1,
    FORM_IMM = 2'd2
  } form_e;

  typedef enum logic [1:0] {
    KIND_SCALAR = 2'd0,
    KIND_MIXED  = 2'd1,
    KIND_VECTOR = 2'd2
  } kind_e;
endpackage

// File: rtl/svseq_bank_adv.sv
module svseq_bank_adv
  import svseq_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]  reg_i,
  input  logic [SP_LOW-1:0] step_i,
  input  logic              dbl_i,
  output logic [REG_W-1:0]  reg_o
);
  logic [SP_LOW-1:0] lo_sp;
  logic [DP_LOW-1:0] lo_dp;

  always_comb begin
    lo_sp = reg_i[SP_LOW-1:0] + step_i;
    lo_dp = reg_i[DP_LOW-1:0] + step_i[DP_LOW-1:0];
    if (dbl_i) reg_o = {reg_i[REG_W-1:DP_LOW], lo_dp};
    else       reg_o = {reg_i[REG_W-1:SP_LOW], lo_sp};
  end
endmodule

// File: rtl/svseq_classify.sv
module svseq_classify
  import svseq_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int STR_W = 2
) (
  input  logic [SP_LOW+1:DP_LOW] dst_bank_i,
  input  logic [SP_LOW+1:DP_LOW] srcb_bank_i,
  input  logic                   dbl_i,
  input  form_e                  form_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [STR_W-1:0]       stride_i,
  output kind_e                  kind_o,
  output logic [LEN_W-1:0]       last_idx_o,
  output logic [SP_LOW-1:0]      step_d_o,
  output logic [SP_LOW-1:0]      step_b_o
);
  logic dst_scl, srcb_scl, one_elem;
  logic [SP_LOW-1:0] str_ext;

  function automatic logic in_scalar_bank(input logic [SP_LOW+1:DP_LOW] b,
                                          input logic dbl);
    if (dbl) return b[DP_LOW+1:DP_LOW] == '0;
    return b[SP_LOW+1:SP_LOW] == '0;
  endfunction

  always_comb begin
    dst_scl  = in_scalar_bank(dst_bank_i, dbl_i);
    srcb_scl = in_scalar_bank(srcb_bank_i, dbl_i);
    one_elem = dst_scl || (len_i == '0);
    str_ext  = {{(SP_LOW-STR_W){1'b0}}, stride_i};
    step_d_o = dbl_i ? ((str_ext >> 1) + SP_LOW'(1)) : (str_ext + SP_LOW'(1));
    if (one_elem)                kind_o = KIND_SCALAR;
    else if (form_i == FORM_IMM) kind_o = KIND_VECTOR;
    else if (srcb_scl)           kind_o = KIND_MIXED;
    else                         kind_o = KIND_VECTOR;
    last_idx_o = one_elem ? '0 : len_i;
    step_b_o   = (kind_o == KIND_VECTOR && form_i != FORM_IMM) ? step_d_o : '0;
  end
endmodule

// File: rtl/svseq_top.sv
module svseq_top
  import svseq_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LEN_W = 3,
  parameter int STR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       form_i,
  input  logic             dbl_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] srca_i,
  input  logic [REG_W-1:0] srcb_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [STR_W-1:0] stride_i,
  output logic             busy_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [REG_W-1:0] out_dst_o,
  output logic [REG_W-1:0] out_srca_o,
  output logic [REG_W-1:0] out_srcb_o,
  output logic [LEN_W-1:0] out_idx_o,
  output logic             out_last_o,
  output logic [1:0]       out_kind_o,
  output logic             out_lda_o,
  output logic             out_ldb_o
);
  localparam int NOPS = 3;  // 0 destination, 1 first source, 2 second source

  kind_e             kind_c, kind_q;
  logic [LEN_W-1:0]  last_c, last_q, idx_q;
  logic [SP_LOW-1:0] step_d_c, step_b_c, step_d_q, step_b_q;
  form_e             form_q;
  logic              dbl_q, valid_q;
  logic [REG_W-1:0]  cur_q [NOPS];
  logic [REG_W-1:0]  nxt_c [NOPS];
  logic              take, acc;

  svseq_classify #(.LEN_W(LEN_W), .STR_W(STR_W)) u_cls (
    .dst_bank_i (dst_i[SP_LOW+1:DP_LOW]),
    .srcb_bank_i(srcb_i[SP_LOW+1:DP_LOW]),
    .dbl_i      (dbl_i),
    .form_i     (form_e'(form_i)),
    .len_i      (len_i),
    .stride_i   (stride_i),
    .kind_o     (kind_c),
    .last_idx_o (last_c),
    .step_d_o   (step_d_c),
    .step_b_o   (step_b_c)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_adv
    svseq_bank_adv #(.REG_W(REG_W)) u_adv (
      .reg_i (cur_q[g]),
      .step_i((g == NOPS-1) ? step_b_q : step_d_q),
      .dbl_i (dbl_q),
      .reg_o (nxt_c[g])
    );
  end

  assign take = start_i && !valid_q;
  assign acc  = valid_q && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      kind_q   <= KIND_SCALAR;
      form_q   <= FORM_3OP;
      dbl_q    <= 1'b0;
      step_d_q <= '0;
      step_b_q <= '0;
      for (int i = 0; i < NOPS; i++) cur_q[i] <= '0;
    end else if (take) begin
      valid_q  <= 1'b1;
      idx_q    <= '0;
      last_q   <= last_c;
      kind_q   <= kind_c;
      form_q   <= form_e'(form_i);
      dbl_q    <= dbl_i;
      step_d_q <= step_d_c;
      step_b_q <= step_b_c;
      cur_q[0] <= dst_i;
      cur_q[1] <= srca_i;
      cur_q[2] <= srcb_i;
    end else if (acc) begin
      if (idx_q == last_q) begin
        valid_q <= 1'b0;
      end else begin
        idx_q <= idx_q + LEN_W'(1);
        for (int i = 0; i < NOPS; i++) cur_q[i] <= nxt_c[i];
      end
    end
  end

  assign busy_o      = valid_q;
  assign out_valid_o = valid_q;
  assign out_dst_o   = cur_q[0];
  assign out_srca_o  = cur_q[1];
  assign out_srcb_o  = cur_q[2];
  assign out_idx_o   = idx_q;
  assign out_last_o  = valid_q && (idx_q == last_q);
  assign out_kind_o  = kind_q;
  assign out_lda_o   = valid_q && (form_q == FORM_3OP);
  assign out_ldb_o   = valid_q && (form_q != FORM_IMM) &&
                       ((idx_q == '0) || (kind_q == KIND_VECTOR));

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_dst_o) &&
      $stable(out_srca_o) && $stable(out_srcb_o) && $stable(out_idx_o)));

  // R10
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_last_o) |=> !busy_o);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !out_last_o) |=>
      (out_valid_o && out_idx_o == $past(out_idx_o) + LEN_W'(1)));

  // R2
  scalar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_kind_o == KIND_SCALAR) |-> (out_last_o && out_idx_o == '0));

  // R5
  sp_bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !out_last_o && !dbl_q) |=>
      (out_dst_o[REG_W-1:SP_LOW] == $past(out_dst_o[REG_W-1:SP_LOW])));

  // R6
  mixed_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !out_last_o && out_kind_o == KIND_MIXED) |=>
      $stable(out_srcb_o));

  // R8
  imm_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && form_q == FORM_IMM) |-> (!out_lda_o && !out_ldb_o &&
      out_kind_o != KIND_MIXED));
endmodule

// File: tb/test_svseq_top.sv
module test_svseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] form_i = '0;
  logic       dbl_i = 1'b0;
  logic [4:0] dst_i = '0, srca_i = '0, srcb_i = '0;
  logic [2:0] len_i = '0;
  logic [1:0] stride_i = '0;
  logic       out_ready_i = 1'b0;
  logic       busy_o, out_valid_o, out_last_o, out_lda_o, out_ldb_o;
  logic [4:0] out_dst_o, out_srca_o, out_srcb_o;
  logic [2:0] out_idx_o;
  logic [1:0] out_kind_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  svseq_top i_svseq_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .form_i(form_i), .dbl_i(dbl_i),
    .dst_i(dst_i), .srca_i(srca_i), .srcb_i(srcb_i), .len_i(len_i),
    .stride_i(stride_i), .busy_o(busy_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_dst_o(out_dst_o), .out_srca_o(out_srca_o),
    .out_srcb_o(out_srcb_o), .out_idx_o(out_idx_o), .out_last_o(out_last_o),
    .out_kind_o(out_kind_o), .out_lda_o(out_lda_o), .out_ldb_o(out_ldb_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int adv(input int r, input int s, input int dbl);
    if (dbl != 0) return (r & ~3) | ((r + s) & 3);
    return (r & ~7) | ((r + s) & 7);
  endfunction

  function automatic bit scl(input int r, input int dbl);
    if (dbl != 0) return ((r >> 2) & 3) == 0;
    return ((r >> 3) & 3) == 0;
  endfunction

  // Issue one request and check every element; stall toggles ready, poke
  // sends a start with other values while the sequence is running.
  task automatic run_op(input string tag, input int dst, input int a, input int b,
                        input int len, input int stride, input int dbl, input int form,
                        input bit stall, input bit poke);
    int n, stp, sb, kind, ed, ea, eb, elem, cyc;
    bit one;
    one  = (len == 0) || scl(dst, dbl);
    n    = one ? 1 : len + 1;
    stp  = (dbl != 0) ? (stride >> 1) + 1 : stride + 1;
    kind = one ? 0 : (form == 2) ? 2 : scl(b, dbl) ? 1 : 2;
    sb   = (kind == 2 && form != 2) ? stp : 0;
    ed = dst; ea = a; eb = b;
    @(negedge clk);
    start_i = 1'b1; form_i = 2'(form); dbl_i = 1'(dbl);
    dst_i = 5'(dst); srca_i = 5'(a); srcb_i = 5'(b);
    len_i = 3'(len); stride_i = 2'(stride);
    @(negedge clk);
    start_i = 1'b0;
    elem = 0; cyc = 0;
    while (elem < n && cyc < 64) begin
      out_ready_i = stall ? cyc[0] : 1'b1;
      if (poke && cyc == 1) begin
        start_i = 1'b1; dst_i = 5'd31; srca_i = 5'd1; srcb_i = 5'd30; len_i = 3'd7;
      end else begin
        start_i = 1'b0;
      end
      chk(tag, "valid", int'(out_valid_o), 1);
      chk(tag, "dst", int'(out_dst_o), ed);
      chk(tag, "srca", int'(out_srca_o), ea);
      chk(tag, "srcb", int'(out_srcb_o), eb);
      chk("R3", "idx", int'(out_idx_o), elem);
      chk("R3", "last", int'(out_last_o), int'(elem == n - 1));
      chk("R1", "kind", int'(out_kind_o), kind);
      chk("R7", "lda", int'(out_lda_o), int'(form == 0));
      chk("R7", "ldb", int'(out_ldb_o), int'(form != 2 && (elem == 0 || kind == 2)));
      if (out_ready_i) begin
        elem++;
        ed = adv(ed, stp, dbl); ea = adv(ea, stp, dbl); eb = adv(eb, sb, dbl);
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    out_ready_i = 1'b0;
    chk("R10", "valid after last", int'(out_valid_o), 0);
    chk("R10", "busy after last", int'(busy_o), 0);
    @(negedge clk);
    chk("R10", "still idle", int'(out_valid_o), 0);
  endtask

  task automatic t_reset();
    chk("R11", "valid at reset", int'(out_valid_o), 0);
    chk("R11", "busy at reset", int'(busy_o), 0);
  endtask

  task automatic t_vector_sp();  run_op("R3", 8, 16, 12, 3, 0, 0, 0, 1'b0, 1'b0); endtask
  task automatic t_wrap_sp();    run_op("R5", 14, 22, 29, 3, 1, 0, 0, 1'b0, 1'b0); endtask
  task automatic t_stride_sp();  run_op("R4", 9, 17, 25, 4, 3, 0, 0, 1'b0, 1'b0); endtask
  task automatic t_mixed_sp();   run_op("R6", 8, 16, 3, 2, 0, 0, 0, 1'b0, 1'b0); endtask
  task automatic t_scalar_dst(); run_op("R2", 5, 9, 20, 5, 0, 0, 0, 1'b0, 1'b0); endtask
  task automatic t_len_zero();   run_op("R2", 12, 9, 20, 0, 0, 0, 0, 1'b0, 1'b0); endtask
  task automatic t_dbl_stride(); run_op("R4", 4, 8, 12, 2, 3, 1, 0, 1'b0, 1'b0); endtask
  task automatic t_dbl_mixed();  run_op("R1", 6, 13, 17, 3, 0, 1, 0, 1'b0, 1'b0); endtask
  task automatic t_dbl_scalar(); run_op("R1", 18, 8, 12, 3, 0, 1, 0, 1'b0, 1'b0); endtask
  task automatic t_broadcast();  run_op("R7", 9, 0, 2, 3, 0, 0, 1, 1'b0, 1'b0); endtask
  task automatic t_two_vec();    run_op("R7", 26, 0, 10, 2, 1, 0, 1, 1'b0, 1'b0); endtask
  task automatic t_imm();        run_op("R8", 24, 0, 3, 2, 0, 0, 2, 1'b0, 1'b0); endtask
  task automatic t_stall();      run_op("R9", 11, 19, 27, 4, 0, 0, 0, 1'b1, 1'b0); endtask
  task automatic t_busy_start(); run_op("R10", 8, 16, 24, 3, 0, 0, 0, 1'b0, 1'b1); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector_sp();
    t_wrap_sp();
    t_stride_sp();
    t_mixed_sp();
    t_scalar_dst();
    t_len_zero();
    t_dbl_stride();
    t_dbl_mixed();
    t_dbl_scalar();
    t_broadcast();
    t_two_vec();
    t_imm();
    t_stall();
    t_busy_start();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule